// File: doc/BRIEF.md
# Software-Triggered ADC Sequencer

This block is the control logic of a four-channel analog-input module that sits in a 256-byte window on a byte-wide register bus. Software sets up the module through ordinary register writes. It turns the module on, picks a settling timebase and a settling count, loads one or more scan-list entries, and resets the counters and the scan position. A conversion then starts as a side effect of reading one particular address.

Once started, the sequencer counts the settling time down at the selected tick rate. It then gives an external converter a one-cycle start pulse and waits for the converter's done flag. When done arrives, it captures the 16-bit two's-complement sample and drops its busy flag. The mux select, mux enable and gain code come from the scan-list entry at the current scan position. That position steps forward after each completed conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Address 0x00 reads the identity byte 0x77. The enable register (0x10), option register (0x11), last-entry register (0x13) and settling register (0x15) read back the byte last written. Status bit 5 mirrors option bit 5.
- R2: A read of address 0x04 starts a conversion only while bit 2 of 0x10 is 1 and the sequencer is idle. Status bit 7 (address 0x12) is 1 from the next cycle on. With bit 2 at 0 the read is ignored: no start pulse is issued and status stays 0x00.
- R3: Option bits [2:1] hold a timebase code c, which gives one settling tick every BASE^c clocks (BASE is a parameter). For a settling count N, the converter start pulse appears N*BASE^c+1 cycles after the clock edge that takes the start read.
- R4: The converter start output is high for exactly one cycle per conversion. Status bit 7 stays 1 from the start read until the converter reports done.
- R5: The clock edge that samples converter done high, with a start pulse already issued, captures the sample and clears status bit 7. The sample reads as its low byte at 0x02 and its high byte at 0x03.
- R6: A start read while busy neither restarts nor shortens the settling wait and issues no extra start pulse. It sets status bit 2, which stays set until a write to 0x1B clears it.
- R7: Each write to 0x80 stores bits [5:0] into the next scan-list entry. Bits [1:0] are the channel, bit 2 the mux enable, bits [4:3] the gain code and bit 5 the local-only flag. Any write to 0x19 puts both the write pointer and the scan position back to entry 0.
- R8: The mux select, mux enable and gain outputs, and reads of 0x80, show the entry at the scan position. After each conversion the position steps forward. It wraps to 0 when the next index would reach the value in 0x13 or the list depth, so a value of 0 or 1 keeps entry 0.
- R9: A write to 0x1B during the settling wait restarts the wait from the full count. The start pulse then appears N*BASE^c+1 cycles after the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address within the module window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a read of 0x04 requests a conversion |
| bus_rdata | output | 8 | Read data for bus_addr |
| mux_sel | output | 2 | Analog channel select of the current entry |
| mux_en | output | 1 | Mux enable of the current entry |
| gain_sel | output | 2 | Gain code of the current entry |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | RES_W | Converter sample, two's complement |

## Verification
The bench builds the block with a timebase base of 2, so the four codes give tick periods of 1, 2, 4 and 8 clocks. It uses a scan list of four entries. With these values, every timebase code can be combined with a range of settling counts, and each start latency can be checked exactly against N*2^c+1 within a few dozen cycles. The short list lets the scan position be driven through every wrap case: wrap at the last-entry value, at the list depth, and with a value of 0 or 1.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam logic [7:0] ADR_ID       = 8'h00;
   localparam logic [7:0] ADR_RES_LO   = 8'h02;
   localparam logic [7:0] ADR_RES_HI   = 8'h03;
   localparam logic [7:0] ADR_START    = 8'h04;
   localparam logic [7:0] ADR_ENABLE   = 8'h10;
   localparam logic [7:0] ADR_OPTION   = 8'h11;
   localparam logic [7:0] ADR_STATUS   = 8'h12;
   localparam logic [7:0] ADR_LAST     = 8'h13;
   localparam logic [7:0] ADR_SETTLE   = 8'h15;
   localparam logic [7:0] ADR_SCAN_RST = 8'h19;
   localparam logic [7:0] ADR_CNT_RST  = 8'h1B;
   localparam logic [7:0] ADR_LIST     = 8'h80;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_CONV   = 2'd2
   } sq_state_t;

   typedef struct packed {
      logic       local_only;
      logic [1:0] gain;
      logic       mux_en;
      logic [1:0] chan;
   } scan_entry_t;

   function automatic int unsigned ipow(input int unsigned b, input int unsigned e);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < e; i++) r = r * b;
      return r;
   endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick
   import adc_seq_pkg::*;
#(
   parameter int unsigned TB_BASE = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clr,
   input  logic [1:0] code,
   output logic       tick
);

   localparam int unsigned P_MAX = ipow(TB_BASE, 3);
   localparam int unsigned PW    = (P_MAX < 2) ? 1 : $clog2(P_MAX);

   generate
      if (TB_BASE < 1 || P_MAX > (1 << 24)) begin : g_bad_base
         $error("adc_seq_tick: TB_BASE out of range");
      end
   endgenerate

   logic [PW-1:0] term [4];
   logic [PW-1:0] cnt;

   generate
      for (genvar k = 0; k < 4; k++) begin : g_term
         assign term[k] = PW'(ipow(TB_BASE, k) - 1);
      end
   endgenerate

   assign tick = run && !clr && (cnt == term[code]);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || clr || tick) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             enable,
   input  logic             reload,
   input  logic [7:0]       settle_cnt,
   input  logic             tick,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data,
   output logic             busy,
   output logic             run,
   output logic             conv_start,
   output logic             done_evt,
   output logic [RES_W-1:0] result
);

   sq_state_t  state;
   logic [7:0] cnt;

   assign busy     = (state != SQ_IDLE);
   assign run      = (state == SQ_SETTLE);
   assign done_evt = (state == SQ_CONV) && conv_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         cnt        <= '0;
         conv_start <= 1'b0;
         result     <= '0;
      end else begin
         conv_start <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (start_req && enable) begin
                  state <= SQ_SETTLE;
                  cnt   <= settle_cnt;
               end
            end
            SQ_SETTLE: begin
               if (reload) begin
                  cnt <= settle_cnt;
               end else if (cnt == 8'd0) begin
                  state      <= SQ_CONV;
                  conv_start <= 1'b1;
               end else if (tick) begin
                  cnt <= cnt - 8'd1;
               end
            end
            SQ_CONV: begin
               if (conv_done) begin
                  result <= conv_data;
                  state  <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R2: an accepted start makes the sequencer busy with no pulse yet
   a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && enable && !busy) |=> (busy && !conv_start));

   // R4: the start pulse lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R4: the pulse only occurs while busy
   a_r4_pulse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R5: busy only drops after the converter reported done
   a_r5_busy_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(conv_done));

   // R5: the captured sample only changes on a done event
   a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done_evt |=> $stable(result));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W      = 16,
   parameter int unsigned LIST_DEPTH = 4,
   parameter logic [7:0]  ID_VAL     = 8'h77
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [7:0]       bus_wdata,
   input  logic             bus_rd,
   output logic [7:0]       bus_rdata,
   input  logic             busy,
   input  logic             done_evt,
   input  logic [RES_W-1:0] result,
   output logic             enable,
   output logic [1:0]       tb_code,
   output logic [7:0]       settle_cnt,
   output logic             reload,
   output logic             start_req,
   output logic [1:0]       mux_sel,
   output logic             mux_en,
   output logic [1:0]       gain_sel
);

   localparam int unsigned IW = (LIST_DEPTH < 2) ? 1 : $clog2(LIST_DEPTH);

   generate
      if (RES_W < 9 || RES_W > 16) begin : g_bad_resw
         $error("adc_seq_regs: RES_W must be 9..16");
      end
      if (LIST_DEPTH < 1 || LIST_DEPTH > 128) begin : g_bad_depth
         $error("adc_seq_regs: LIST_DEPTH must be 1..128");
      end
   endgenerate

   logic [7:0]  en_q, opt_q, settle_q, last_q;
   logic        err_q;
   logic [IW-1:0] wptr, spos, spos_nxt;
   logic [IW:0]   inc;
   logic          wrap;
   logic          list_we, scan_rst;
   logic [15:0]   res16;
   scan_entry_t   ent [LIST_DEPTH];
   scan_entry_t   cur;

   assign start_req = bus_rd && (bus_addr == ADR_START);
   assign reload    = bus_wr && (bus_addr == ADR_CNT_RST);
   assign scan_rst  = bus_wr && (bus_addr == ADR_SCAN_RST);
   assign list_we   = bus_wr && (bus_addr == ADR_LIST);

   assign enable     = en_q[2];
   assign tb_code    = opt_q[2:1];
   assign settle_cnt = settle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         opt_q    <= '0;
         settle_q <= '0;
         last_q   <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            ADR_ENABLE: en_q     <= bus_wdata;
            ADR_OPTION: opt_q    <= bus_wdata;
            ADR_SETTLE: settle_q <= bus_wdata;
            ADR_LAST:   last_q   <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           err_q <= 1'b0;
      else if (reload)      err_q <= 1'b0;
      else if (start_req && busy) err_q <= 1'b1;
   end

   generate
      for (genvar g = 0; g < LIST_DEPTH; g++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)                             ent[g] <= '0;
            else if (list_we && wptr == IW'(g))     ent[g] <= scan_entry_t'(bus_wdata[5:0]);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || scan_rst) wptr <= '0;
      else if (list_we)       wptr <= (int'(wptr) == LIST_DEPTH - 1) ? '0 : wptr + 1'b1;
   end

   assign inc      = {1'b0, spos} + 1'b1;
   assign wrap     = (int'(inc) >= int'(last_q)) || (int'(inc) >= LIST_DEPTH);
   assign spos_nxt = wrap ? '0 : inc[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || scan_rst) spos <= '0;
      else if (done_evt)      spos <= spos_nxt;
   end

   assign cur      = ent[spos];
   assign mux_sel  = cur.chan;
   assign mux_en   = cur.mux_en;
   assign gain_sel = cur.gain;

   assign res16 = 16'($signed(result));

   always_comb begin
      case (bus_addr)
         ADR_ID:     bus_rdata = ID_VAL;
         ADR_RES_LO: bus_rdata = res16[7:0];
         ADR_RES_HI: bus_rdata = res16[15:8];
         ADR_ENABLE: bus_rdata = en_q;
         ADR_OPTION: bus_rdata = opt_q;
         ADR_STATUS: bus_rdata = {busy, 1'b0, opt_q[5], 2'b00, err_q, 2'b00};
         ADR_LAST:   bus_rdata = last_q;
         ADR_SETTLE: bus_rdata = settle_q;
         ADR_LIST:   bus_rdata = {2'b00, cur};
         default:    bus_rdata = 8'h00;
      endcase
   end

   // R6: a start while busy raises the error flag
   a_r6_err_on_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && busy && !reload) |=> err_q);

   // R7: a scan reset returns pointer and position to entry 0
   a_r7_scan_reset: assert property (@(posedge clk) disable iff (!rst_n)
      scan_rst |=> (spos == '0 && wptr == '0));

   // R8: the scan position only moves on a completed conversion
   a_r8_pos_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_evt && !scan_rst) |=> $stable(spos));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W      = 16,
   parameter int unsigned LIST_DEPTH = 4,
   parameter int unsigned TB_BASE    = 10,
   parameter logic [7:0]  ID_VAL     = 8'h77
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [7:0]       bus_wdata,
   input  logic             bus_rd,
   output logic [7:0]       bus_rdata,
   output logic [1:0]       mux_sel,
   output logic             mux_en,
   output logic [1:0]       gain_sel,
   output logic             conv_start,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data
);

   logic             enable, reload, start_req;
   logic             busy, run, tick, done_evt;
   logic [1:0]       tb_code;
   logic [7:0]       settle_cnt;
   logic [RES_W-1:0] result;

   adc_seq_regs #(
      .RES_W(RES_W), .LIST_DEPTH(LIST_DEPTH), .ID_VAL(ID_VAL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .busy(busy), .done_evt(done_evt), .result(result),
      .enable(enable), .tb_code(tb_code), .settle_cnt(settle_cnt),
      .reload(reload), .start_req(start_req),
      .mux_sel(mux_sel), .mux_en(mux_en), .gain_sel(gain_sel)
   );

   adc_seq_tick #(.TB_BASE(TB_BASE)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(reload),
      .code(tb_code), .tick(tick)
   );

   adc_seq_fsm #(.RES_W(RES_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start_req(start_req), .enable(enable), .reload(reload),
      .settle_cnt(settle_cnt), .tick(tick),
      .conv_done(conv_done), .conv_data(conv_data),
      .busy(busy), .run(run), .conv_start(conv_start),
      .done_evt(done_evt), .result(result)
   );

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   import adc_seq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [1:0]  mux_sel;
   logic        mux_en;
   logic [1:0]  gain_sel;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = 16'h0000;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   int start_cnt = 0;
   int start_cyc = 0;
   int op_cyc = 0;
   logic [7:0] lst [4];

   always #2 clk = ~clk;

   adc_seq_ctrl #(.RES_W(16), .LIST_DEPTH(4), .TB_BASE(2), .ID_VAL(8'h77)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .mux_sel(mux_sel), .mux_en(mux_en), .gain_sel(gain_sel),
      .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      if (conv_start) begin
         start_cnt = start_cnt + 1;
         start_cyc = cyc;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      op_cyc = cyc;
   endtask

   task automatic rd_start();
      @(negedge clk);
      bus_addr = ADR_START; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      op_cyc = cyc;
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_pulse(input int s0, input int t0, output int lat);
      int w;
      w = 0;
      while (start_cnt == s0 && w < 3000) begin
         @(negedge clk);
         w++;
      end
      lat = (start_cnt == s0) ? -1 : (start_cyc - t0);
   endtask

   task automatic finish_conv(input logic [15:0] d, input string req);
      logic [7:0] s;
      peek(ADR_STATUS, s);
      chk({req, " R4 busy while converting"}, 32'(s[7]), 32'd1);
      conv_data = d; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk({req, " R4 start pulse one cycle"}, 32'(conv_start), 32'd0);
      peek(ADR_STATUS, s);
      chk({req, " R5 busy cleared after done"}, 32'(s[7]), 32'd0);
   endtask

   task automatic run_conv(input logic [15:0] d, output int lat);
      int s0, t0;
      s0 = start_cnt;
      rd_start();
      t0 = op_cyc;
      wait_pulse(s0, t0, lat);
      finish_conv(d, "conv");
   endtask

   task automatic chk_entry(input int pos);
      logic [7:0] e, r;
      e = lst[pos];
      chk("R8 mux_sel", 32'(mux_sel), 32'(e[1:0]));
      chk("R8 mux_en", 32'(mux_en), 32'(e[2]));
      chk("R8 gain_sel", 32'(gain_sel), 32'(e[4:3]));
      peek(ADR_LIST, r);
      chk("R7 list readback", 32'(r), 32'(e & 8'h3F));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int lat, s0, t0, tw, pos, lim;
      logic [15:0] d;
      int nl [5];
      nl[0] = 0; nl[1] = 1; nl[2] = 2; nl[3] = 5; nl[4] = 9;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      peek(ADR_ID, r);     chk("R1 id after reset", 32'(r), 32'h77);
      peek(ADR_STATUS, r); chk("R2 status after reset", 32'(r), 32'h00);
      peek(ADR_RES_LO, r); chk("R5 result low after reset", 32'(r), 32'h00);
      chk("R4 no pulse after reset", 32'(conv_start), 32'd0);
      chk("R8 mux_sel after reset", 32'(mux_sel), 32'd0);

      // R1 register readback
      wr(ADR_ENABLE, 8'h5C); peek(ADR_ENABLE, r); chk("R1 enable readback", 32'(r), 32'h5C);
      wr(ADR_OPTION, 8'h2B); peek(ADR_OPTION, r); chk("R1 option readback", 32'(r), 32'h2B);
      peek(ADR_STATUS, r);   chk("R1 status mirrors option bit5", 32'(r[5]), 32'd1);
      wr(ADR_SETTLE, 8'hA7); peek(ADR_SETTLE, r); chk("R1 settle readback", 32'(r), 32'hA7);
      wr(ADR_LAST, 8'h03);   peek(ADR_LAST, r);   chk("R1 last readback", 32'(r), 32'h03);

      // R2 start ignored while disabled
      wr(ADR_ENABLE, 8'h00);
      wr(ADR_OPTION, 8'h00);
      wr(ADR_SETTLE, 8'h00);
      s0 = start_cnt;
      rd_start();
      repeat (20) @(negedge clk);
      chk("R2 no pulse when disabled", 32'(start_cnt), 32'(s0));
      peek(ADR_STATUS, r); chk("R2 status stays 0 when disabled", 32'(r), 32'h00);

      // R3/R4/R5 sweep over timebase and settling count
      wr(ADR_ENABLE, 8'h04);
      for (int c = 0; c < 4; c++) begin
         for (int ni = 0; ni < 5; ni++) begin
            wr(ADR_OPTION, 8'(c << 1));
            wr(ADR_SETTLE, 8'(nl[ni]));
            d = 16'((c * 7919 + nl[ni] * 131) ^ 16'h8001);
            run_conv(d, lat);
            chk("R3 start latency", 32'(lat), 32'(nl[ni] * (1 << c) + 1));
            peek(ADR_RES_LO, r); chk("R5 result low byte", 32'(r), 32'(d[7:0]));
            peek(ADR_RES_HI, r); chk("R5 result high byte", 32'(r), 32'(d[15:8]));
         end
      end

      // R6 start while busy
      wr(ADR_OPTION, 8'h02);
      wr(ADR_SETTLE, 8'd10);
      s0 = start_cnt;
      rd_start();
      t0 = op_cyc;
      repeat (4) @(negedge clk);
      rd_start();
      peek(ADR_STATUS, r); chk("R6 busy-start flag set", 32'(r[2]), 32'd1);
      wait_pulse(s0, t0, lat);
      chk("R6 latency unchanged by busy start", 32'(lat), 32'd21);
      finish_conv(16'h1234, "R6");
      repeat (30) @(negedge clk);
      chk("R6 single start pulse", 32'(start_cnt), 32'(s0 + 1));
      peek(ADR_STATUS, r); chk("R6 flag sticky", 32'(r[2]), 32'd1);

      // R9 counter reset restarts settling, clears flag
      wr(ADR_OPTION, 8'h00);
      wr(ADR_SETTLE, 8'd6);
      s0 = start_cnt;
      rd_start();
      repeat (3) @(negedge clk);
      wr(ADR_CNT_RST, 8'h00);
      tw = op_cyc;
      peek(ADR_STATUS, r); chk("R6 flag cleared by counter reset", 32'(r[2]), 32'd0);
      wait_pulse(s0, tw, lat);
      chk("R9 latency from counter reset", 32'(lat), 32'd7);
      finish_conv(16'hFEDC, "R9");

      // R7/R8 scan list
      lst[0] = 8'h0C; lst[1] = 8'h31; lst[2] = 8'h1E; lst[3] = 8'h03;
      wr(ADR_SCAN_RST, 8'h00);
      for (int i = 0; i < 4; i++) wr(ADR_LIST, lst[i]);
      wr(ADR_LAST, 8'd3);
      wr(ADR_SETTLE, 8'd0);
      pos = 0;
      chk_entry(pos);
      for (int k = 0; k < 5; k++) begin
         run_conv(16'(k), lat);
         pos = (pos + 1 >= 3) ? 0 : pos + 1;
         chk_entry(pos);
      end
      wr(ADR_SCAN_RST, 8'h00);
      pos = 0;
      chk_entry(pos);
      wr(ADR_LAST, 8'd1);
      for (int k = 0; k < 2; k++) begin
         run_conv(16'h00AA, lat);
         chk_entry(0);
      end
      wr(ADR_LAST, 8'd9);
      lim = 4;
      pos = 0;
      for (int k = 0; k < 5; k++) begin
         run_conv(16'h0055, lat);
         pos = (pos + 1 >= lim) ? 0 : pos + 1;
         chk_entry(pos);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule